// File: doc/BRIEF.md
# Iterative Subtractive GCD Engine

This block finds the greatest common divisor of two unsigned integers. A pair of operands enters through a valid/ready input. Two working registers take the pair. On each clock the engine then replaces the working pair (a, b) with (|a − b|, min(a, b)), writing both values in the same edge. The step logic is a comparator that picks the larger and smaller value, one subtractor and the steering multiplexers. The operand width is a parameter.

The loop stops when either working register holds zero. The non-zero register, or zero if both are zero, is copied into a separate result register. The engine then raises a result-valid flag. The result and the flag stay unchanged until the next operand pair is accepted.

The rules at the input are these. A pair is taken on a rising clock edge when `op_valid` and `op_ready` are both high. `op_ready` is high only when the engine is idle or holding a finished result. While a computation runs, `op_ready` is low and `op_valid` has no effect. The result side has no back-pressure. `res_valid` is a plain status pin that stays high until the next pair is accepted.

Top module: `gcd_engine`

## Requirements
- R1: While `rst_n` is low, and after its release until the first accepted pair, `res_valid` is 0, `res_gcd` is 0 and `op_ready` is 1.
- R2: The pair `op_a`/`op_b` is captured on a rising edge where `op_valid` and `op_ready` are both 1. After that edge `op_ready` stays 0 until the result is ready.
- R3: During a computation, if both working values are non-zero, each edge replaces (a, b) with (|a − b|, min(a, b)) in a single update.
- R4: On the first edge where a working value is zero, the result takes the other working value and `res_valid` rises. For a pair that needs k steps to reach a zero, `res_valid` is first seen high k+1 cycles after the capturing edge.
- R5: When `res_valid` is high, `res_gcd` equals the greatest common divisor of the captured pair.
- R6: For the pair (0, 0) the result is 0 and `res_valid` is high one cycle after the capturing edge.
- R7: If exactly one operand is zero, the result is the other operand, and it is ready one cycle after capture.
- R8: For equal non-zero operands x, the result is x and it is ready two cycles after capture.
- R9: `op_valid` pulses while a computation runs, with other operand values, are ignored: the result is still that of the captured pair.
- R10: While no new pair is accepted, `res_valid` stays 1 and `res_gcd` keeps its value. One cycle after a new pair is accepted, `res_valid` is 0.
- R11: The operand and result width follows the parameter `WIDTH`. The extreme values 1 and 2^WIDTH − 1 give correct results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operand pair is present |
| op_ready | output | 1 | The engine can take a pair (idle or result held) |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| res_valid | output | 1 | `res_gcd` holds a finished result |
| res_gcd | output | WIDTH | Greatest common divisor |

## Verification
The time to a result depends on the data. For each pair the bench counts k, the number of difference/minimum steps needed to reach a zero, and expects `res_valid` exactly k+1 edges after the capturing edge. It counts edges from the capture and samples `res_valid` on every falling edge, so both early and late completion are caught. The captured pair is also checked against a remainder-based GCD. Ignored input pulses are checked one sample after they are driven (`op_ready` low) and again when the result arrives. The held result is checked again several cycles after completion, and once more one cycle after a new capture.

// File: rtl/gcd_pkg.sv
package gcd_pkg;
  typedef enum logic [1:0] {
    GCD_IDLE = 2'd0,
    GCD_RUN  = 2'd1,
    GCD_HOLD = 2'd2
  } gcd_state_e;
endpackage

// File: rtl/gcd_step.sv
module gcd_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] diff_o,
  output logic [WIDTH-1:0] min_o
);
  logic             a_lt_b;
  logic [WIDTH-1:0] larger;
  logic [WIDTH-1:0] smaller;

  // comparator feeding both steering muxes
  always_comb begin
    a_lt_b  = (a_i < b_i);
    larger  = a_lt_b ? b_i : a_i;
    smaller = a_lt_b ? a_i : b_i;
    diff_o  = larger - smaller;
    min_o   = smaller;
  end
endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic op_valid,
  input  logic any_zero,
  output logic op_ready,
  output logic load_en,
  output logic step_en,
  output logic finish_en,
  output logic res_valid
);
  gcd_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    load_en   = 1'b0;
    step_en   = 1'b0;
    finish_en = 1'b0;
    op_ready  = 1'b0;
    res_valid = 1'b0;
    unique case (state_q)
      GCD_IDLE: begin
        op_ready = 1'b1;
        if (op_valid) begin
          load_en = 1'b1;
          state_d = GCD_RUN;
        end
      end
      GCD_RUN: begin
        if (any_zero) begin
          finish_en = 1'b1;
          state_d   = GCD_HOLD;
        end else begin
          step_en = 1'b1;
        end
      end
      GCD_HOLD: begin
        op_ready  = 1'b1;
        res_valid = 1'b1;
        if (op_valid) begin
          load_en = 1'b1;
          state_d = GCD_RUN;
        end
      end
      default: state_d = GCD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GCD_IDLE;
    else        state_q <= state_d;
  end

  // a result only appears after a busy cycle
  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $past(!op_ready));

  // a busy cycle never captures operands
  assert_busy_no_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_ready && op_valid) |=> (!op_ready || res_valid));
endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             step_en,
  input  logic             finish_en,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             any_zero,
  output logic [WIDTH-1:0] res_gcd
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] a_q, b_q, res_q;
  logic [WIDTH-1:0] diff_w, min_w;

  gcd_step #(.WIDTH(WIDTH)) u_step (
    .a_i    (a_q),
    .b_i    (b_q),
    .diff_o (diff_w),
    .min_o  (min_w)
  );

  assign any_zero = (a_q == ZERO) || (b_q == ZERO);
  assign res_gcd  = res_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= ZERO;
      b_q <= ZERO;
    end else if (load_en) begin
      a_q <= op_a;
      b_q <= op_b;
    end else if (step_en) begin
      a_q <= diff_w;
      b_q <= min_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         res_q <= ZERO;
    else if (finish_en) res_q <= a_q | b_q;
  end

  assert_load_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (a_q == $past(op_a) && b_q == $past(op_b)));

  assert_step_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (a_q == (($past(a_q) > $past(b_q)) ? ($past(a_q) - $past(b_q))
                                                     : ($past(b_q) - $past(a_q)))
              && b_q == (($past(a_q) < $past(b_q)) ? $past(a_q) : $past(b_q))));

  assert_result_other_R4: assert property (@(posedge clk) disable iff (!rst_n)
    finish_en |=> res_q == (($past(a_q) == ZERO) ? $past(b_q) : $past(a_q)));
endmodule

// File: rtl/gcd_engine.sv
module gcd_engine #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             res_valid,
  output logic [WIDTH-1:0] res_gcd
);
  logic load_en, step_en, finish_en, any_zero;

  gcd_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .any_zero  (any_zero),
    .op_ready  (op_ready),
    .load_en   (load_en),
    .step_en   (step_en),
    .finish_en (finish_en),
    .res_valid (res_valid)
  );

  gcd_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .step_en   (step_en),
    .finish_en (finish_en),
    .op_a      (op_a),
    .op_b      (op_b),
    .any_zero  (any_zero),
    .res_gcd   (res_gcd)
  );

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !(op_valid && op_ready)) |=> (res_valid && $stable(res_gcd)));

  assert_drop_on_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_valid) |=> !res_valid);
endmodule

// File: tb/gcd_engine_bench.sv
module gcd_engine_bench;
  localparam int W = 8;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         op_valid = 1'b0;
  logic         op_ready;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         res_valid;
  logic [W-1:0] res_gcd;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  gcd_engine #(.WIDTH(W)) u_gcd_engine (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_a(op_a), .op_b(op_b), .res_valid(res_valid), .res_gcd(res_gcd)
  );

  function automatic int ref_gcd(int x, int y);
    int t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  // steps of the difference/minimum rule until a zero appears
  function automatic int step_count(int x, int y);
    int n = 0;
    int nx;
    while (x != 0 && y != 0) begin
      nx = (x > y) ? x - y : y - x;
      y  = (x < y) ? x : y;
      x  = nx;
      n++;
    end
    return n;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive a pair, count edges to result, check value and latency
  task automatic run_pair(int a, int b, bit busy_poke, string req);
    int lat = 0;
    int exp_lat = step_count(a, b) + 1;
    @(negedge clk);
    op_a = a[W-1:0]; op_b = b[W-1:0]; op_valid = 1'b1;
    @(posedge clk);
    #1 op_valid = 1'b0;
    do begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (busy_poke && lat == 1 && !res_valid) begin
        check(op_ready == 1'b0, "R2 busy ready", int'(op_ready), 0);
        op_a = 8'd77; op_b = 8'd11; op_valid = 1'b1;
      end
      if (busy_poke && lat == 3) op_valid = 1'b0;
    end while (!res_valid && lat < 1000);
    op_valid = 1'b0;
    check(res_gcd == ref_gcd(a, b)[W-1:0], req, int'(res_gcd), ref_gcd(a, b));
    check(lat == exp_lat, "R4 latency", lat, exp_lat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int a, b;
    logic [W-1:0] held;
    void'($urandom(32'd2024));
    #12;
    check(res_valid == 1'b0 && res_gcd == '0 && op_ready == 1'b1, "R1 in reset",
          int'(res_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(res_valid == 1'b0 && res_gcd == '0 && op_ready == 1'b1, "R1 after release",
          int'(res_gcd), 0);

    run_pair(0, 0, 1'b0, "R6 zero pair");
    run_pair(0, 45, 1'b0, "R7 a zero");
    run_pair(90, 0, 1'b0, "R7 b zero");
    run_pair(37, 37, 1'b0, "R8 equal");
    run_pair(35, 64, 1'b0, "R5 coprime");
    run_pair(1, 1, 1'b0, "R11 ones");
    run_pair(int'(MAXV), 1, 1'b0, "R11 max and one");
    run_pair(int'(MAXV), int'(MAXV), 1'b0, "R11 max equal");
    run_pair(48, 180, 1'b0, "R3 shared factor");
    run_pair(200, 3, 1'b1, "R9 busy pulses ignored");

    // R10 hold with no new pair
    held = res_gcd;
    repeat (5) @(negedge clk);
    check(res_valid == 1'b1 && res_gcd == held, "R10 hold", int'(res_gcd), int'(held));
    op_a = 8'd12; op_b = 8'd18; op_valid = 1'b1;
    @(posedge clk); #1 op_valid = 1'b0;
    @(negedge clk);
    check(res_valid == 1'b0, "R10 drop after accept", int'(res_valid), 0);
    while (!res_valid) @(negedge clk);
    check(res_gcd == 8'd6, "R5 after drop", int'(res_gcd), 6);

    for (int i = 0; i < 60; i++) begin
      a = int'($urandom_range(0, int'(MAXV)));
      b = (i % 3 == 0) ? a * int'($urandom_range(1, 3)) % (int'(MAXV) + 1)
                       : int'($urandom_range(0, int'(MAXV)));
      run_pair(a, b, 1'b0, "R5 random");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule